// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two interrupt lines that let the two ports of a shared 4K-location memory signal each other. Each port has a reserved mailbox word at the top of the address space. When one port writes the mailbox of the other port, it raises that port's interrupt. The receiving port then reads its own mailbox word, and that read drops its interrupt. No data passes through this block. It watches only the address and control strobes of both ports and keeps one flag per port.

Each port presents an address, an active-low chip enable, a read/write select (high means read) and an active-low output enable. Both ports are sampled on the same clock edge. Each flag is a register, so an interrupt line changes one cycle after the access that causes the change. Both interrupt outputs are active low.

Top module: `dual_port_mailbox_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `left_irq_n` and `right_irq_n` are high (inactive).
- R2: A right-port write to address 0xFFE drives `left_irq_n` low from the next cycle on.
- R3: A left-port read of address 0xFFE returns `left_irq_n` high in the next cycle, unless a set of the same flag happens in the same cycle.
- R4: A left-port write to address 0xFFF drives `right_irq_n` low from the next cycle on.
- R5: A right-port read of address 0xFFF returns `right_irq_n` high in the next cycle, unless a set of the same flag happens in the same cycle.
- R6: A write counts only when the chip enable is low and read/write is low. A mailbox write with chip enable high, or with read/write high, does not set a flag.
- R7: A read counts only when the chip enable is low, the output enable is low and read/write is high. A mailbox read with output enable high or chip enable high does not clear a flag.
- R8: When a set and a clear of the same flag fall in one cycle, the flag ends up set (interrupt low).
- R9: Accesses to any address other than 0xFFE and 0xFFF leave both interrupt outputs unchanged.
- R10: A mailbox access in the wrong direction leaves both flags unchanged. These accesses are: left write or right read of 0xFFE, and right write or left read of 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| left_addr | input | 12 | Left port address |
| left_ce_n | input | 1 | Left port chip enable, active low |
| left_rw | input | 1 | Left port direction, 1 = read, 0 = write |
| left_oe_n | input | 1 | Left port output enable, active low |
| right_addr | input | 12 | Right port address |
| right_ce_n | input | 1 | Right port chip enable, active low |
| right_rw | input | 1 | Right port direction, 1 = read, 0 = write |
| right_oe_n | input | 1 | Right port output enable, active low |
| left_irq_n | output | 1 | Interrupt to the left port, active low |
| right_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
On every cycle, the assertions check three things. A decoded set forces the matching interrupt low in the next cycle. A decoded clear without a set releases it. A cycle with neither keeps the line steady. This covers the set-over-clear priority and the hold behaviour for both flags. Some requirements can only be shown by the bench's scenarios. Only the bench checks that the decoders pick the right strobe combinations and addresses: the enable gating, the wrong-direction mailbox accesses, ordinary addresses, and a reset in the middle of a run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Port indices; flag k belongs to (interrupts) port k
   localparam int unsigned PORT_LEFT  = 0;
   localparam int unsigned PORT_RIGHT = 1;
   localparam int unsigned NUM_PORTS  = 2;

   // Mailbox slot k sits at the (NUM_PORTS - k)-th word from the top.
   function automatic int unsigned slot_offset(input int unsigned slot);
      return NUM_PORTS - slot;
   endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned N_SLOT = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              rw,
   input  logic              oe_n,
   output logic [N_SLOT-1:0] wr_hit,
   output logic [N_SLOT-1:0] rd_hit
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic wr_qual;
   logic rd_qual;

   // Strobe qualification for a whole port
   assign wr_qual = !ce_n && !rw;
   assign rd_qual = !ce_n && rw && !oe_n;

   // One comparator per mailbox slot, counted down from the top word
   for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR =
         ADDR_W'(DEPTH - mbx_pkg::slot_offset(s));
      logic match;
      assign match     = (addr == SLOT_ADDR);
      assign wr_hit[s] = wr_qual && match;
      assign rd_hit[s] = rd_qual && match;
   end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   logic flag_q;

   // Set wins over clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign irq_n = !flag_q;

endmodule

// File: rtl/dual_port_mailbox_irq.sv
module dual_port_mailbox_irq #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic              left_ce_n,
   input  logic              left_rw,
   input  logic              left_oe_n,
   input  logic [ADDR_W-1:0] right_addr,
   input  logic              right_ce_n,
   input  logic              right_rw,
   input  logic              right_oe_n,
   output logic              left_irq_n,
   output logic              right_irq_n
);
   import mbx_pkg::*;

   localparam int unsigned NP = NUM_PORTS;

   // Elaboration-time parameter checks
   if (ADDR_W < 2) begin : g_bad_width
      $error("ADDR_W must be at least 2 to hold two mailbox words");
   end
   if (ADDR_W > 31) begin : g_bad_width_hi
      $error("ADDR_W above 31 is not supported");
   end

   logic [ADDR_W-1:0] addr_a [NP];
   logic [NP-1:0]     ce_n_a;
   logic [NP-1:0]     rw_a;
   logic [NP-1:0]     oe_n_a;
   logic [NP-1:0]     wr_hit_a [NP];
   logic [NP-1:0]     rd_hit_a [NP];
   logic [NP-1:0]     set_v;
   logic [NP-1:0]     clr_v;
   logic [NP-1:0]     irq_n_v;

   assign addr_a[PORT_LEFT]  = left_addr;
   assign addr_a[PORT_RIGHT] = right_addr;
   assign ce_n_a = {right_ce_n, left_ce_n};
   assign rw_a   = {right_rw,   left_rw};
   assign oe_n_a = {right_oe_n, left_oe_n};

   for (genvar p = 0; p < NP; p++) begin : g_port
      mbx_port_decode #(.ADDR_W(ADDR_W), .N_SLOT(NP)) u_dec (
         .addr   (addr_a[p]),
         .ce_n   (ce_n_a[p]),
         .rw     (rw_a[p]),
         .oe_n   (oe_n_a[p]),
         .wr_hit (wr_hit_a[p]),
         .rd_hit (rd_hit_a[p])
      );
   end

   // Flag k: set by the other port writing slot k, cleared by port k reading it
   for (genvar k = 0; k < NP; k++) begin : g_flag
      assign set_v[k] = wr_hit_a[NP-1-k][k];
      assign clr_v[k] = rd_hit_a[k][k];
      mbx_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (set_v[k]),
         .clr   (clr_v[k]),
         .irq_n (irq_n_v[k])
      );
   end

   assign left_irq_n  = irq_n_v[PORT_LEFT];
   assign right_irq_n = irq_n_v[PORT_RIGHT];

   // R2 / R8: a set on the left flag lowers its interrupt next cycle
   a_r2_left_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[PORT_LEFT] |=> !left_irq_n);
   // R3: a lone clear releases the left interrupt
   a_r3_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[PORT_LEFT] && !set_v[PORT_LEFT]) |=> left_irq_n);
   // R4 / R8: a set on the right flag lowers its interrupt next cycle
   a_r4_right_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[PORT_RIGHT] |=> !right_irq_n);
   // R5: a lone clear releases the right interrupt
   a_r5_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[PORT_RIGHT] && !set_v[PORT_RIGHT]) |=> right_irq_n);
   // R9: no decoded event keeps each line steady
   a_r9_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_v[PORT_LEFT] && !clr_v[PORT_LEFT]) |=> $stable(left_irq_n));
   a_r9_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_v[PORT_RIGHT] && !clr_v[PORT_RIGHT]) |=> $stable(right_irq_n));

endmodule

// File: tb/dual_port_mailbox_irq_test.sv
module dual_port_mailbox_irq_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] left_addr,  right_addr;
   logic        left_ce_n,  left_rw,  left_oe_n;
   logic        right_ce_n, right_rw, right_oe_n;
   logic        left_irq_n, right_irq_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dual_port_mailbox_irq uut (
      .clk(clk), .rst_n(rst_n),
      .left_addr(left_addr), .left_ce_n(left_ce_n), .left_rw(left_rw), .left_oe_n(left_oe_n),
      .right_addr(right_addr), .right_ce_n(right_ce_n), .right_rw(right_rw), .right_oe_n(right_oe_n),
      .left_irq_n(left_irq_n), .right_irq_n(right_irq_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_both(input string req, input logic el, input logic er);
      chk({req, " left_irq_n"},  left_irq_n,  el);
      chk({req, " right_irq_n"}, right_irq_n, er);
   endtask

   task automatic idle();
      left_addr = 12'h000; left_ce_n = 1'b1; left_rw = 1'b1; left_oe_n = 1'b1;
      right_addr = 12'h000; right_ce_n = 1'b1; right_rw = 1'b1; right_oe_n = 1'b1;
   endtask

   // One cycle of access on both ports; returns at the negedge after the edge
   task automatic cyc(input logic [11:0] la, input logic lce, input logic lrw, input logic loe,
                      input logic [11:0] ra, input logic rce, input logic rrw, input logic roe);
      @(negedge clk);
      left_addr = la;  left_ce_n = lce;  left_rw = lrw;  left_oe_n = loe;
      right_addr = ra; right_ce_n = rce; right_rw = rrw; right_oe_n = roe;
      @(negedge clk);
      idle();
   endtask

   localparam logic [11:0] MB_L = 12'hFFE;
   localparam logic [11:0] MB_R = 12'hFFF;

   task automatic t_reset();
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_both("R1 in reset", 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      chk_both("R1 after reset", 1'b1, 1'b1);
   endtask

   task automatic t_left_set_clear();
      cyc(12'h000, 1, 1, 1, MB_L, 0, 0, 1);      // right writes 0xFFE
      chk_both("R2 right write FFE", 1'b0, 1'b1);
      cyc(12'h123, 0, 0, 1, 12'hFFD, 0, 1, 0);   // other addresses
      chk_both("R9 other addresses", 1'b0, 1'b1);
      cyc(MB_L, 0, 0, 1, MB_L, 0, 1, 0);         // left writes / right reads 0xFFE
      chk_both("R10 wrong-direction FFE", 1'b0, 1'b1);
      cyc(MB_L, 0, 1, 1, 12'h000, 1, 1, 1);      // left read, oe_n high
      chk_both("R7 read without oe", 1'b0, 1'b1);
      cyc(MB_L, 1, 1, 0, 12'h000, 1, 1, 1);      // left read, ce_n high
      chk_both("R7 read without ce", 1'b0, 1'b1);
      cyc(MB_L, 0, 1, 0, 12'h000, 1, 1, 1);      // left reads 0xFFE
      chk_both("R3 left read FFE", 1'b1, 1'b1);
   endtask

   task automatic t_right_set_clear();
      cyc(MB_R, 1, 0, 1, 12'h000, 1, 1, 1);      // write with ce_n high
      chk_both("R6 write without ce", 1'b1, 1'b1);
      cyc(MB_R, 0, 1, 1, 12'h000, 1, 1, 1);      // rw high, no oe
      chk_both("R6 write with rw high", 1'b1, 1'b1);
      cyc(12'h000, 1, 1, 1, MB_L, 1, 0, 1);      // right write FFE, ce_n high
      chk_both("R6 right write without ce", 1'b1, 1'b1);
      cyc(MB_R, 0, 0, 1, 12'h000, 1, 1, 1);      // left writes 0xFFF
      chk_both("R4 left write FFF", 1'b1, 1'b0);
      cyc(MB_R, 0, 1, 0, MB_R, 0, 0, 1);         // left reads / right writes 0xFFF
      chk_both("R10 wrong-direction FFF", 1'b1, 1'b0);
      cyc(12'h7FF, 0, 0, 1, 12'hFFD, 0, 0, 1);   // near-miss addresses
      chk_both("R9 near-miss writes", 1'b1, 1'b0);
      cyc(12'h000, 1, 1, 1, MB_R, 0, 1, 0);      // right reads 0xFFF
      chk_both("R5 right read FFF", 1'b1, 1'b1);
   endtask

   task automatic t_priority();
      cyc(MB_L, 0, 1, 0, MB_L, 0, 0, 1);         // clear + set, flag was clear
      chk_both("R8 left set beats clear", 1'b0, 1'b1);
      cyc(MB_L, 0, 1, 0, MB_L, 0, 0, 1);         // again while set
      chk_both("R8 left stays set", 1'b0, 1'b1);
      cyc(MB_R, 0, 0, 1, MB_R, 0, 1, 0);
      chk_both("R8 right set beats clear", 1'b0, 1'b0);
      cyc(MB_L, 0, 1, 0, MB_R, 0, 1, 0);         // both read their mailboxes
      chk_both("R3 R5 both clear", 1'b1, 1'b1);
      cyc(MB_R, 0, 0, 1, MB_L, 0, 0, 1);         // both write the other mailbox
      chk_both("R2 R4 both set", 1'b0, 1'b0);
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_both("R1 mid-run reset", 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      chk_both("R1 after mid-run reset", 1'b1, 1'b1);
   endtask

   initial begin
      t_reset();
      t_left_set_clear();
      t_right_set_clear();
      t_priority();
      t_mid_reset();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule